// File: doc/BRIEF.md
# Integer Arithmetic Unit with Overflow Trap

This block is the arithmetic part of the execute stage in a load-store RISC datapath. It has no internal state. The first operand is always a register value. The second operand is either a second register value or a 16-bit immediate, which the block sign-extends itself. A 3-bit operation code selects one of six operations: add and subtract, each in a trapping and a non-trapping form, and set-less-than in a signed and an unsigned form.

The trapping forms raise an overflow flag when the true two's-complement result does not fit in the word. When that flag is raised, the write-enable output drops so that the pipeline leaves the destination register unchanged. The non-trapping forms wrap silently and always write. The comparisons write a word that is exactly one or zero. Comparisons are taken from the subtractor path, so the signed comparison stays correct even when the internal subtraction overflows.

Top module: `alu_trap`

## Requirements
- R1: For codes 3'b000 (trapping add) and 3'b001 (wrapping add), the result is the sum of the two operands modulo 2^32.
- R2: For codes 3'b010 (trapping sub) and 3'b011 (wrapping sub), the result is the first operand plus the bitwise inverse of the second operand plus one, modulo 2^32.
- R3: For code 3'b000, the overflow flag is 1 exactly when both operands have the same sign and the sign of the result differs from that sign.
- R4: For code 3'b010, the overflow flag is 1 exactly when the operands differ in sign and the sign of the result differs from the sign of the first operand.
- R5: Codes 3'b001 and 3'b011 never raise the overflow flag, and they always assert write enable.
- R6: For the valid codes 3'b000 through 3'b101, write enable is the inverse of the overflow flag.
- R7: Code 3'b100 yields 32'd1 when the first operand is less than the second as two's-complement numbers, and 32'd0 otherwise. This holds at the extremes, where the internal difference overflows.
- R8: Code 3'b101 yields 32'd1 when the first operand is less than the second as an unsigned number from 0 to 2^32-1, and 32'd0 otherwise.
- R9: When the immediate-select input is 1, the second operand is the immediate with its bit 15 copied into bits 31..16. This applies to every code, including the unsigned comparison.
- R10: Codes 3'b110 and 3'b111 give a zero result, write enable 0 and overflow flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| use_imm | input | 1 | 1 selects the sign-extended immediate as the second operand |
| op_sel | input | 3 | Operation code |
| result | output | 32 | Arithmetic or comparison result |
| ovf_trap | output | 1 | Overflow exception request |
| wr_en | output | 1 | Destination write qualifier |

## Verification
Directed vectors sit on the signed limits 32'h7fffffff and 32'h80000000 and on the unsigned limits 0 and 32'hffffffff. These values separate the carry-based unsigned decision from the sign-based overflow decision, and they show whether the signed comparison survives an overflowing difference. Immediate vectors with bit 15 set tell true sign extension apart from zero extension, most visibly under the unsigned comparison. Random vectors cover all eight codes with both operand sources. Their operands are drawn with a bias towards the limits, and each one is compared against a reference model that computes overflow in 64-bit arithmetic.

// File: rtl/alu_trap.sv
module alu_trap #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_imm,
  input  logic [2:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             ovf_trap,
  output logic             wr_en
);
  localparam int EXT_W = WIDTH - IMM_W;
  localparam logic [2:0] OP_ADD  = 3'b000;
  localparam logic [2:0] OP_ADDU = 3'b001;
  localparam logic [2:0] OP_SUB  = 3'b010;
  localparam logic [2:0] OP_SUBU = 3'b011;
  localparam logic [2:0] OP_SLT  = 3'b100;
  localparam logic [2:0] OP_SLTU = 3'b101;

  logic [WIDTH-1:0] imm_ext, b_src, b_add, sum;
  logic             carry, is_sub, ovf_raw, lt_s, lt_u;

  assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign b_src   = use_imm ? imm_ext : opnd_b;
  assign is_sub  = (op_sel == OP_SUB) || (op_sel == OP_SUBU) ||
                   (op_sel == OP_SLT) || (op_sel == OP_SLTU);
  assign b_add   = is_sub ? ~b_src : b_src;

  assign {carry, sum} = {1'b0, opnd_a} + {1'b0, b_add} + {{WIDTH{1'b0}}, is_sub};

  assign ovf_raw = (opnd_a[WIDTH-1] == b_add[WIDTH-1]) &&
                   (sum[WIDTH-1] != opnd_a[WIDTH-1]);
  assign lt_s = sum[WIDTH-1] ^ ovf_raw;
  assign lt_u = ~carry;

  always_comb begin
    result   = '0;
    ovf_trap = 1'b0;
    wr_en    = 1'b1;
    case (op_sel)
      OP_ADD, OP_SUB: begin
        result   = sum;
        ovf_trap = ovf_raw;
        wr_en    = ~ovf_raw;
      end
      OP_ADDU, OP_SUBU: result = sum;
      OP_SLT:  result = {{(WIDTH-1){1'b0}}, lt_s};
      OP_SLTU: result = {{(WIDTH-1){1'b0}}, lt_u};
      default: wr_en = 1'b0;
    endcase
  end
endmodule

module alu_trap_chk #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [IMM_W-1:0] imm,
  input logic             use_imm,
  input logic [2:0]       op_sel,
  input logic [WIDTH-1:0] result,
  input logic             ovf_trap,
  input logic             wr_en
);
  logic sa, sb;
  assign sa = opnd_a[WIDTH-1];
  assign sb = use_imm ? imm[IMM_W-1] : opnd_b[WIDTH-1];

  always_comb begin
    if (op_sel == 3'b001 || op_sel == 3'b011)
      a_r5_nontrap_quiet: assert (!ovf_trap && wr_en);
    if (op_sel <= 3'b101)
      a_r6_trap_blocks_write: assert (wr_en == !ovf_trap);
    if (op_sel >= 3'b110)
      a_r10_unused_idle: assert (result == '0 && !wr_en && !ovf_trap);
    if (op_sel == 3'b100 || op_sel == 3'b101)
      a_r7_cmp_binary: assert (result[WIDTH-1:1] == '0);
    if (op_sel == 3'b000)
      a_r3_add_trap: assert (ovf_trap == ((sa == sb) && (result[WIDTH-1] != sa)));
    if (op_sel == 3'b010)
      a_r4_sub_trap: assert (ovf_trap == ((sa != sb) && (result[WIDTH-1] != sa)));
  end
endmodule

bind alu_trap alu_trap_chk #(.WIDTH(WIDTH), .IMM_W(IMM_W)) chk_i (
  .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm), .use_imm(use_imm),
  .op_sel(op_sel), .result(result), .ovf_trap(ovf_trap), .wr_en(wr_en)
);

// File: tb/alu_trap_tb.sv
module alu_trap_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] a, b, res;
  logic [15:0] imm;
  logic        ui, trap, we;
  logic [2:0]  op;
  int checks = 0, fails = 0;
  bit done = 0;

  alu_trap dut_i (.opnd_a(a), .opnd_b(b), .imm(imm), .use_imm(ui), .op_sel(op),
                  .result(res), .ovf_trap(trap), .wr_en(we));

  function automatic void model(input logic [31:0] ma, mb, input logic [15:0] mi,
                                input logic mu, input logic [2:0] mo,
                                output logic [31:0] r, output logic t, output logic w);
    logic [31:0] bb;
    longint sa, sb, s;
    bb = mu ? {{16{mi[15]}}, mi} : mb;
    sa = longint'($signed(ma));
    sb = longint'($signed(bb));
    s = 0;
    case (mo)
      3'd0, 3'd1: begin s = sa + sb; r = ma + bb; end
      3'd2, 3'd3: begin s = sa - sb; r = ma - bb; end
      3'd4: r = ($signed(ma) < $signed(bb)) ? 32'd1 : 32'd0;
      3'd5: r = (ma < bb) ? 32'd1 : 32'd0;
      default: r = 32'd0;
    endcase
    t = (mo == 3'd0 || mo == 3'd2) && (s > 64'sd2147483647 || s < -64'sd2147483648);
    w = (mo <= 3'd5) && !t;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h ui=%0b got=%h exp=%h",
               tag, op, a, b, imm, ui, got, exp);
    end
  endtask

  task automatic run(input logic [31:0] ta, tb, input logic [15:0] ti,
                     input logic tu, input logic [2:0] to, input string xtag);
    logic [31:0] er;
    logic et, ew;
    string rt, tt;
    @(posedge clk);
    a = ta; b = tb; imm = ti; ui = tu; op = to;
    @(negedge clk);
    model(ta, tb, ti, tu, to, er, et, ew);
    case (to)
      3'd0, 3'd1: rt = "R1";
      3'd2, 3'd3: rt = "R2";
      3'd4: rt = "R7";
      3'd5: rt = "R8";
      default: rt = "R10";
    endcase
    case (to)
      3'd0: tt = "R3";
      3'd2: tt = "R4";
      3'd1, 3'd3: tt = "R5";
      3'd4, 3'd5: tt = "R6";
      default: tt = "R10";
    endcase
    chk({rt, xtag}, res, er);
    chk({tt, " trap"}, {31'd0, trap}, {31'd0, et});
    chk((to > 3'd5) ? "R10 we" : "R6 we", {31'd0, we}, {31'd0, ew});
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 6)
      0: return 32'h7fffffff;
      1: return 32'h80000000;
      2: return 32'hffffffff;
      3: return 32'd0;
      4: return 32'h7fffffff + ($urandom % 3) - 1;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    a = 0; b = 0; imm = 0; ui = 0; op = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle result", res, 32'd0);
    chk("R6 idle we", {31'd0, we}, 32'd1);

    run(32'h7fffffff, 32'd1, 16'd0, 0, 3'd0, " max+1");
    run(32'h7fffffff, 32'd1, 16'd0, 0, 3'd1, " wrap");
    run(32'h80000000, 32'hffffffff, 16'd0, 0, 3'd0, " min+-1");
    run(32'h80000000, 32'd1, 16'd0, 0, 3'd2, " min-1");
    run(32'h7fffffff, 32'hffffffff, 16'd0, 0, 3'd2, " max--1");
    run(32'h80000000, 32'd1, 16'd0, 0, 3'd3, " wrap");
    run(32'h80000000, 32'h7fffffff, 16'd0, 0, 3'd4, " ovf cmp");
    run(32'h7fffffff, 32'h80000000, 16'd0, 0, 3'd4, " ovf cmp");
    run(32'h80000000, 32'h7fffffff, 16'd0, 0, 3'd5, " cmp");
    run(32'd0, 32'hffffffff, 16'd0, 0, 3'd5, " cmp");
    run(32'd0, 32'd0, 16'h8000, 1, 3'd1, " R9 addi");
    run(32'h7fffffff, 32'd0, 16'h0001, 1, 3'd0, " R9 addi trap");
    run(32'd0, 32'd0, 16'hffff, 1, 3'd4, " R9 slti");
    run(32'd5, 32'd0, 16'hffff, 1, 3'd5, " R9 sltiu");
    run(32'hffff0000, 32'd0, 16'h8000, 1, 3'd5, " R9 sltiu");
    run(32'h12345678, 32'h9abcdef0, 16'd0, 0, 3'd6, " unused");
    run(32'h7fffffff, 32'd1, 16'h7fff, 1, 3'd7, " unused");

    for (int i = 0; i < 3000; i++)
      run(pick(), pick(), 16'($urandom), 1'($urandom), 3'($urandom), " rnd");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule